// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a way into a second, slower register space through a small window of local registers. The host loads a target address and, for a store, the data to store. It then starts one transaction by writing a single control word. A clear direction bit in that word starts a fetch; a set direction bit starts a store. The bridge carries the transaction out on a downstream request/acknowledge port whose latency is unbounded. When the transaction ends, the bridge raises a ready flag that software polls. Data fetched from downstream is held in a read-data register until the next fetch completes.

A configuration field of a few bits is driven continuously to the downstream side. A programmable cycle limit bounds how long the bridge waits for an acknowledge; a limit of zero lets it wait forever. A control write that arrives while a transaction is running is dropped and sets a sticky error flag.

Host window offsets (3-bit offset): 0 target address, 1 store data, 2 control/status, 3 fetched data (read only), 4 downstream configuration, 5 timeout limit. A control write uses bit 0 as the direction (1 = store, 0 = fetch) and bit 3 to clear the overrun flag. A status read returns bit 0 ready, bit 1 busy, bit 2 timed out and bit 3 overrun, with all higher bits zero.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the status reads 0x1 (ready only), `dn_req` is low, the configuration register reads 0 and the timeout limit reads the parameter default (64).
- R2: The target address, store data and timeout limit registers read back what was written. The configuration register keeps only its low PW (4) bits.
- R3: A control write with bit 0 = 1 starts a store: `dn_req` rises with `dn_we` = 1, and `dn_addr`/`dn_wdata` carry the latched address and store data.
- R4: A control write with bit 0 = 0 starts a fetch. On acknowledge, `dn_rdata` is captured into the fetched-data register. A completed store leaves that register unchanged.
- R5: The control write that starts a transaction clears ready on the same clock edge that raises `dn_req`. Busy (status bit 1) is then 1, and ready stays low until the transaction ends.
- R6: `dn_req` stays high until `dn_ack` is seen (or a timeout). While it is high, `dn_we`, `dn_addr` and `dn_wdata` hold steady even if the host rewrites its window registers.
- R7: A control write during a running transaction is ignored (no direction change, no extra downstream request) and sets the sticky overrun bit. The bit survives later accepted starts and is cleared only by an accepted start with control bit 3 set.
- R8: With limit L > 0, a transaction with no acknowledge holds `dn_req` for exactly L cycles, then aborts with ready = 1 and the timed-out bit set. An acknowledge arriving within the window wins. The next accepted start clears the timed-out bit.
- R9: A timeout limit of 0 disables the timeout, so an arbitrarily late acknowledge still completes normally.
- R10: `dn_param` continuously drives the configuration register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe for the window |
| hst_addr | input | 3 | Window register offset |
| hst_wdata | input | DW (32) | Host write data |
| hst_rdata | output | DW (32) | Window register read data (combinational on `hst_addr`) |
| dn_req | output | 1 | Downstream request, held until acknowledge or timeout |
| dn_we | output | 1 | Downstream direction, 1 = store |
| dn_addr | output | AW (16) | Downstream target address |
| dn_wdata | output | DW (32) | Downstream store data |
| dn_rdata | input | DW (32) | Downstream fetched data, valid with `dn_ack` |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_param | output | PW (4) | Downstream configuration field |

## Verification
The hardest situations to reach are the ones where two things race: a second control write landing while a request is still outstanding, and an acknowledge arriving on the last cycle of the timeout window. The bench's downstream responder has a latency it can program per transaction, and it can also withhold the acknowledge entirely. This lets the stimulus hold a request open for a known number of cycles. It then fires a conflicting control write inside that window, or places the acknowledge exactly one cycle before the limit expires. A scoreboard of expected downstream transactions shows that the dropped write never produced a request and never flipped the direction.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int unsigned HA_W = 3;

  localparam logic [HA_W-1:0] OFS_ADDR = 3'd0;
  localparam logic [HA_W-1:0] OFS_WDAT = 3'd1;
  localparam logic [HA_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [HA_W-1:0] OFS_RDAT = 3'd3;
  localparam logic [HA_W-1:0] OFS_PARM = 3'd4;
  localparam logic [HA_W-1:0] OFS_TLIM = 3'd5;

  localparam int unsigned CB_DIR   = 0;
  localparam int unsigned CB_OVCLR = 3;

  localparam int unsigned ST_W = 4;

  // Abort when the count about to be reached equals the limit; 0 = never.
  function automatic logic tmo_expire(input int unsigned cnt, input int unsigned lim);
    return (lim != 0) && ((cnt + 1) >= lim);
  endfunction

  function automatic logic [ST_W-1:0] pack_status(input logic rdy, input logic bsy,
                                                  input logic tmo, input logic ovr);
    return {ovr, tmo, bsy, rdy};
  endfunction

endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned PW     = 4,
  parameter int unsigned TW     = 16,
  parameter int unsigned TO_DEF = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [HA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [AW-1:0]   addr_q,
  output logic [DW-1:0]   wdat_q,
  output logic [PW-1:0]   parm_q,
  output logic [TW-1:0]   tlim_q,
  output logic            ctrl_wr,
  output logic            ctrl_dir,
  output logic            ctrl_ovclr
);

  localparam logic [TW-1:0] TLIM_RST = TW'(TO_DEF);

  assign ctrl_wr    = we && (addr == OFS_CTRL);
  assign ctrl_dir   = wdata[CB_DIR];
  assign ctrl_ovclr = wdata[CB_OVCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      parm_q <= '0;
      tlim_q <= TLIM_RST;
    end else if (we) begin
      case (addr)
        OFS_ADDR: addr_q <= wdata[AW-1:0];
        OFS_WDAT: wdat_q <= wdata;
        OFS_PARM: parm_q <= wdata[PW-1:0];
        OFS_TLIM: tlim_q <= wdata[TW-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ctrl_dir,
  input  logic          ctrl_ovclr,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdat_i,
  input  logic [TW-1:0] tlim_i,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  output logic [DW-1:0] rdat_q,
  output logic          ready,
  output logic          tmo,
  output logic          ovr,
  output logic          launch,
  output logic          ignored,
  output logic          to_hit
);

  logic [TW-1:0] cnt_q;
  logic          ack_hit;

  assign launch  = ctrl_wr && !dn_req;
  assign ignored = ctrl_wr && dn_req;
  assign ack_hit = dn_req && dn_ack;
  assign to_hit  = dn_req && !dn_ack && tmo_expire(32'(cnt_q), 32'(tlim_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_req   <= 1'b0;
      dn_we    <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      rdat_q   <= '0;
      cnt_q    <= '0;
      ready    <= 1'b1;
      tmo      <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (launch) begin
        dn_req   <= 1'b1;
        dn_we    <= ctrl_dir;
        dn_addr  <= addr_i;
        dn_wdata <= wdat_i;
        cnt_q    <= '0;
        ready    <= 1'b0;
        tmo      <= 1'b0;
        if (ctrl_ovclr) ovr <= 1'b0;
      end else if (ack_hit) begin
        dn_req <= 1'b0;
        ready  <= 1'b1;
        if (!dn_we) rdat_q <= dn_rdata;
      end else if (to_hit) begin
        dn_req <= 1'b0;
        ready  <= 1'b1;
        tmo    <= 1'b1;
      end else if (dn_req) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ignored) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned PW     = 4,
  parameter int unsigned TW     = 16,
  parameter int unsigned TO_DEF = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_we,
  input  logic [HA_W-1:0] hst_addr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  output logic            dn_req,
  output logic            dn_we,
  output logic [AW-1:0]   dn_addr,
  output logic [DW-1:0]   dn_wdata,
  input  logic [DW-1:0]   dn_rdata,
  input  logic            dn_ack,
  output logic [PW-1:0]   dn_param
);

  logic [AW-1:0] addr_w;
  logic [DW-1:0] wdat_w;
  logic [PW-1:0] parm_w;
  logic [TW-1:0] tlim_w;
  logic [DW-1:0] rdat_w;
  logic          ctrl_wr_w, ctrl_dir_w, ctrl_ovclr_w;
  logic          ready_w, tmo_w, ovr_w;
  logic          launch_w, ignored_w, to_hit_w;

  ibr_host_regs #(.AW(AW), .DW(DW), .PW(PW), .TW(TW), .TO_DEF(TO_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(hst_we), .addr(hst_addr), .wdata(hst_wdata),
    .addr_q(addr_w), .wdat_q(wdat_w), .parm_q(parm_w), .tlim_q(tlim_w),
    .ctrl_wr(ctrl_wr_w), .ctrl_dir(ctrl_dir_w), .ctrl_ovclr(ctrl_ovclr_w)
  );

  ibr_seq #(.AW(AW), .DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr_w), .ctrl_dir(ctrl_dir_w),
    .ctrl_ovclr(ctrl_ovclr_w), .addr_i(addr_w), .wdat_i(wdat_w), .tlim_i(tlim_w),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_req(dn_req), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .rdat_q(rdat_w), .ready(ready_w),
    .tmo(tmo_w), .ovr(ovr_w), .launch(launch_w), .ignored(ignored_w), .to_hit(to_hit_w)
  );

  assign dn_param = parm_w;

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFS_ADDR: hst_rdata[AW-1:0]   = addr_w;
      OFS_WDAT: hst_rdata           = wdat_w;
      OFS_CTRL: hst_rdata[ST_W-1:0] = pack_status(ready_w, dn_req, tmo_w, ovr_w);
      OFS_RDAT: hst_rdata           = rdat_w;
      OFS_PARM: hst_rdata[PW-1:0]   = parm_w;
      OFS_TLIM: hst_rdata[TW-1:0]   = tlim_w;
      default:  hst_rdata           = '0;
    endcase
  end

endmodule

// File: rtl/ibr_chk.sv
module ibr_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          launch,
  input logic          ignored,
  input logic          to_hit,
  input logic          rdy,
  input logic          tmo,
  input logic          ovr,
  input logic          dn_req,
  input logic          dn_ack,
  input logic          dn_we,
  input logic [AW-1:0] dn_addr,
  input logic [DW-1:0] dn_wdata,
  input logic [DW-1:0] dn_rdata,
  input logic [DW-1:0] rdat
);

  p_launch_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!rdy && dn_req));

  p_ready_excl_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_req && rdy));

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack && !to_hit) |=> dn_req);

  p_fields_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack && !to_hit) |=> ($stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  p_fetch_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ack && !dn_we) |=> (rdy && (rdat == $past(dn_rdata))));

  p_ignored_sets_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |=> ovr);

  p_timeout_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (rdy && tmo && !dn_req));

endmodule

bind ind_reg_bridge ibr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch_w), .ignored(ignored_w), .to_hit(to_hit_w),
  .rdy(ready_w), .tmo(tmo_w), .ovr(ovr_w), .dn_req(dn_req), .dn_ack(dn_ack),
  .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
  .rdat(rdat_w)
);

// File: tb/ind_reg_bridge_test.sv
`timescale 1ns/1ps
module ind_reg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_we = 1'b0;
  logic [2:0]  hst_addr = 3'd0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        dn_req, dn_we;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata = '0;
  logic        dn_ack = 1'b0;
  logic [3:0]  dn_param;

  ind_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dn_req(dn_req), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack),
    .dn_param(dn_param)
  );

  always #10 clk = ~clk;

  typedef struct packed { logic we; logic [15:0] a; logic [31:0] d; } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_bad = 0;
  int lat = 0;
  bit no_ack = 1'b0;
  int wcnt = 0;

  function automatic logic [31:0] fetch_val(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      hread(3'd2, s);
      if (s[0]) return;
    end
  endtask

  // driver: loads window, records expectation, starts transaction
  task automatic launch(input logic we, input logic [15:0] a, input logic [31:0] d,
                        input int l, input logic [31:0] ctrl_extra);
    hwrite(3'd0, {16'h0, a});
    if (we) hwrite(3'd1, d);
    lat = l;
    sb_q.push_back('{we: we, a: a, d: d});
    hwrite(3'd2, ctrl_extra | {31'h0, we});
  endtask

  // downstream responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (dn_ack) begin
        dn_ack = 1'b0;
        wcnt = 0;
      end else if (dn_req && !no_ack) begin
        if (wcnt >= lat) begin
          exp_t e;
          dn_rdata = fetch_val(dn_addr);
          dn_ack = 1'b1;
          if (sb_q.size() == 0) begin
            check("R7 unexpected downstream request", 32'(dn_we), 32'hFFFF_FFFF);
          end else begin
            e = sb_q.pop_front();
            check("R3/R4 downstream direction", 32'(dn_we), 32'(e.we));
            check("R6 downstream address", 32'(dn_addr), 32'(e.a));
            if (e.we) check("R3 downstream store data", dn_wdata, e.d);
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(3'd2, v); check("R1 status after reset", v, 32'h1);
    check("R1 dn_req after reset", 32'(dn_req), 32'h0);
    hread(3'd4, v); check("R1 config after reset", v, 32'h0);
    hread(3'd5, v); check("R1 limit after reset", v, 32'd64);

    // R2 / R10 window registers
    hwrite(3'd0, 32'h0000_1234); hread(3'd0, v); check("R2 address readback", v, 32'h1234);
    hwrite(3'd1, 32'hDEAD_BEEF); hread(3'd1, v); check("R2 store data readback", v, 32'hDEAD_BEEF);
    hwrite(3'd4, 32'hFFFF_FFFF); hread(3'd4, v); check("R2 config masked", v, 32'hF);
    check("R10 dn_param", 32'(dn_param), 32'hF);
    hwrite(3'd5, 32'd200); hread(3'd5, v); check("R2 limit readback", v, 32'd200);

    // R3 / R5 / R6 store, host address changed mid-flight
    launch(1'b1, 16'h1234, 32'hCAFE_F00D, 3, 32'h0);
    hread(3'd2, v); check("R5 status while busy", v, 32'h2);
    hwrite(3'd0, 32'h0000_9999);
    wait_ready();
    hread(3'd2, v); check("R5 status after store", v, 32'h1);
    hread(3'd3, v); check("R4 fetched data untouched by store", v, 32'h0);

    // R4 fetch, zero latency
    launch(1'b0, 16'h00A5, 32'h0, 0, 32'h0);
    wait_ready();
    hread(3'd3, v); check("R4 fetched data", v, fetch_val(16'h00A5));

    // R4 / R10 fetch, longer latency, new config
    hwrite(3'd4, 32'h3);
    check("R10 dn_param update", 32'(dn_param), 32'h3);
    launch(1'b0, 16'h7E01, 32'h0, 7, 32'h0);
    wait_ready();
    hread(3'd3, v); check("R4 fetched data long latency", v, fetch_val(16'h7E01));

    // R7 overrun
    launch(1'b0, 16'h0042, 32'h0, 10, 32'h0);
    hwrite(3'd2, 32'h1);
    hread(3'd2, v); check("R7 status busy with overrun", v, 32'hA);
    wait_ready();
    hread(3'd2, v); check("R7 status after overrun txn", v, 32'h9);
    hread(3'd3, v); check("R7 ignored write kept fetch", v, fetch_val(16'h0042));
    launch(1'b0, 16'h0043, 32'h0, 2, 32'h0);
    wait_ready();
    hread(3'd2, v); check("R7 overrun sticky", v, 32'h9);
    launch(1'b0, 16'h0044, 32'h0, 1, 32'h8);
    wait_ready();
    hread(3'd2, v); check("R7 overrun cleared", v, 32'h1);

    // R8 timeout
    hwrite(3'd5, 32'd5);
    no_ack = 1'b1;
    hwrite(3'd0, 32'h0000_0BAD);
    hwrite(3'd2, 32'h0);
    hold = 0;
    for (int i = 0; i < 100; i++) begin
      if (!dn_req) break;
      hold++;
      @(negedge clk);
    end
    check("R8 request hold cycles", 32'(hold), 32'd5);
    hread(3'd2, v); check("R8 status after timeout", v, 32'h5);
    hread(3'd3, v); check("R8 fetched data kept on abort", v, fetch_val(16'h0044));
    no_ack = 1'b0;
    wcnt = 0;

    // R8 acknowledge on last cycle of window wins
    launch(1'b0, 16'h0051, 32'h0, 4, 32'h0);
    wait_ready();
    hread(3'd2, v); check("R8 late ack wins, timeout cleared", v, 32'h1);
    hread(3'd3, v); check("R8 late ack data", v, fetch_val(16'h0051));

    // R9 limit 0 disables timeout
    hwrite(3'd5, 32'd0);
    launch(1'b1, 16'h0200, 32'h1357_9BDF, 150, 32'h0);
    wait_ready();
    hread(3'd2, v); check("R9 no timeout with zero limit", v, 32'h1);

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(sb_q.size()), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule